// File: doc/BRIEF.md
# Bit-Block Transfer Word Datapath

This block carries one 16-bit word of a bit-block transfer from the shared data bus back to the destination write. Each read on the bus is first captured in a holding latch. Depending on whether the bus cycle was a source or a destination read, the value then moves either into the source pair or into the destination register. The source pair holds the current and the previous source word. It is rotated so that the source pixels line up with the destination pixels.

The aligned source word passes through a small FIFO stage. It is then combined with the destination word by one of sixteen logic functions. Edge masks for the first and last word of a line keep the destination pixels that lie outside the transfer. Bit 0 of every word is the leftmost pixel. A line-start strobe empties the source pair so that the first word of a line aligns against zeros, unless a pre-read loads it. The result is driven out only while the output-enable strobe is high.

Top module: `blit_word_unit`

## Requirements
- R1: After reset, all internal words are zero, busOe is low and busOut is zero. With function 1111, output enabled and no edge enabled, the result is 0xFFFF. With function 1010, it is 0x0000.
- R2: A latchStb pulse captures busIn. If srcCycle was 1, the next cycle moves the word into the current source and the old current source into the previous source, and the destination word is left alone. If srcCycle was 0, only the destination word is replaced.
- R3: The aligned source is the upper 16 bits of {previous, current} shifted toward the MSB by shiftAmt (0 to 15). A shiftAmt of 0 therefore yields the previous source word.
- R4: funcSel picks the result bit from the source bit s and destination bit d. The encoding is 0000 zero, 0001 ~s&~d, 0010 ~s&d, 0011 ~s, 0100 s&~d, 0101 ~d, 0110 s^d, 0111 ~s|~d, 1000 s&d, 1001 ~(s^d), 1010 d, 1011 ~s|d, 1100 s, 1101 s|~d, 1110 s|d, 1111 ones.
- R5: The written value is (f & m) | (d & ~m). Here m is leftMask when leftEn is high and all ones otherwise, ANDed with rightMask when rightEn is high and all ones otherwise. A 1 in a mask lets the function output through. A 0 in a mask keeps the destination bit.
- R6: A lineStart pulse clears both source words. If a source transfer happens in the same cycle, the new word is loaded into the current source and the previous source is cleared.
- R7: The FIFO read strobe follows its write strobe by exactly two clocks. A source word captured at edge E0 reaches the logic unit after edge E4, and a destination word captured at E0 is in use after edge E1.
- R8: While outEn is low, busOut is zero and busOe is low. While outEn is high, busOe is high and busOut carries the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIn | input | 16 | Read data from the shared bus |
| latchStb | input | 1 | Capture busIn into the holding latch |
| srcCycle | input | 1 | Captured word is source (1) or destination (0) |
| lineStart | input | 1 | Clear the source pair at the start of a line |
| shiftAmt | input | 4 | Alignment rotate amount toward the MSB |
| funcSel | input | 4 | Logic function code |
| leftEn | input | 1 | Apply leftMask |
| rightEn | input | 1 | Apply rightMask |
| leftMask | input | 16 | Left edge mask, 1 = writable bit |
| rightMask | input | 16 | Right edge mask, 1 = writable bit |
| outEn | input | 1 | Drive the result during the destination write |
| busOut | output | 16 | Result word, zero when not driven |
| busOe | output | 1 | Result is being driven |

## Verification
All sixteen function codes are applied to the fixed pair 0x0F0F and 0x3355, whose four s/d bit combinations expose every truth table. Zero and nonzero shifts are applied right after a line start and in mid-line, which separates clearing of the previous word from rotation into it. A stream of random words, shifts, codes and mask enables then checks the combined path against a bench model. Two directed probes confirm the order of operations: one samples the output one cycle before and at the cycle a new source word must arrive, and the others read the source back after a destination read and the destination after a source read.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef struct packed {
    logic capture;
    logic toSrc;
    logic toDst;
    logic clearPrev;
    logic fifoWr;
    logic fifoRd;
    logic drive;
  } blitStrobes_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         latchStb,
  input  logic         srcCycle,
  input  logic         lineStart,
  input  logic         outEn,
  output blitStrobes_t strb
);
  logic toSrcQ, toDstQ, wrQ;
  logic [1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toSrcQ <= 1'b0;
      toDstQ <= 1'b0;
      wrQ    <= 1'b0;
      rdPipe <= '0;
    end else begin
      toSrcQ <= latchStb & srcCycle;
      toDstQ <= latchStb & ~srcCycle;
      wrQ    <= toSrcQ;
      rdPipe <= {rdPipe[0], wrQ};
    end
  end

  always_comb begin
    strb.capture   = latchStb;
    strb.toSrc     = toSrcQ;
    strb.toDst     = toDstQ;
    strb.clearPrev = lineStart;
    strb.fifoWr    = wrQ;
    strb.fifoRd    = rdPipe[1];
    strb.drive     = outEn;
  end
endmodule

// File: rtl/blit_dpath.sv
module blit_dpath
  import blit_pkg::*;
#(
  parameter int DW         = 16,
  parameter int SHW        = $clog2(DW),
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  blitStrobes_t  strb,
  input  logic [DW-1:0] busIn,
  input  logic [SHW-1:0] shiftAmt,
  input  logic [3:0]    funcSel,
  input  logic          leftEn,
  input  logic          rightEn,
  input  logic [DW-1:0] leftMask,
  input  logic [DW-1:0] rightMask,
  output logic [DW-1:0] busOut,
  output logic          busOe,
  output logic [DW-1:0] curSrcO,
  output logic [DW-1:0] prevSrcO
);
  localparam int PAIR_W = 2 * DW;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [DW-1:0] master, curSrc, prevSrc, dstReg, holdReg;
  logic [DW-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PAIR_W-1:0] shifted;
  logic [DW-1:0] aligned, funcOut, edgeMask, result;

  // alignment: shift the pair toward the MSB, keep the upper half
  always_comb begin
    shifted = {prevSrc, curSrc} << shiftAmt;
    aligned = shifted[PAIR_W-1:DW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      master  <= '0;
      curSrc  <= '0;
      prevSrc <= '0;
      dstReg  <= '0;
      holdReg <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      for (int i = 0; i < FIFO_DEPTH; i++) fifoMem[i] <= '0;
    end else begin
      if (strb.capture) master <= busIn;
      if (strb.clearPrev)  prevSrc <= '0;
      else if (strb.toSrc) prevSrc <= curSrc;
      if (strb.toSrc)          curSrc <= master;
      else if (strb.clearPrev) curSrc <= '0;
      if (strb.toDst) dstReg <= master;
      if (strb.fifoWr) begin
        fifoMem[wrPtr] <= aligned;
        wrPtr <= wrPtr + PTR_W'(1);
      end
      if (strb.fifoRd) begin
        holdReg <= fifoMem[rdPtr];
        rdPtr <= rdPtr + PTR_W'(1);
      end
    end
  end

  // logic unit: each code bit is the output for one (s,d) minterm
  for (genvar b = 0; b < DW; b++) begin : g_blu
    assign funcOut[b] = funcSel[{holdReg[b], dstReg[b]}];
  end

  always_comb begin
    edgeMask = (leftEn ? leftMask : '1) & (rightEn ? rightMask : '1);
    result   = (funcOut & edgeMask) | (dstReg & ~edgeMask);
    busOut   = strb.drive ? result : '0;
    busOe    = strb.drive;
  end

  assign curSrcO  = curSrc;
  assign prevSrcO = prevSrc;
endmodule

// File: rtl/blit_word_unit.sv
module blit_word_unit
  import blit_pkg::*;
#(
  parameter int DW         = 16,
  parameter int SHW        = $clog2(DW),
  parameter int FIFO_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [DW-1:0]  busIn,
  input  logic           latchStb,
  input  logic           srcCycle,
  input  logic           lineStart,
  input  logic [SHW-1:0] shiftAmt,
  input  logic [3:0]     funcSel,
  input  logic           leftEn,
  input  logic           rightEn,
  input  logic [DW-1:0]  leftMask,
  input  logic [DW-1:0]  rightMask,
  input  logic           outEn,
  output logic [DW-1:0]  busOut,
  output logic           busOe
);
  blitStrobes_t strb;
  logic [DW-1:0] curSrc, prevSrc;

  blit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .srcCycle(srcCycle),
    .lineStart(lineStart), .outEn(outEn), .strb(strb)
  );

  blit_dpath #(.DW(DW), .SHW(SHW), .FIFO_DEPTH(FIFO_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn), .shiftAmt(shiftAmt),
    .funcSel(funcSel), .leftEn(leftEn), .rightEn(rightEn),
    .leftMask(leftMask), .rightMask(rightMask), .busOut(busOut), .busOe(busOe),
    .curSrcO(curSrc), .prevSrcO(prevSrc)
  );
endmodule

// File: rtl/blit_word_unit_chk.sv
module blit_word_unit_chk
  import blit_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          outEn,
  input logic [DW-1:0] busOut,
  input logic          busOe,
  input blitStrobes_t  strb,
  input logic [DW-1:0] curSrc,
  input logic [DW-1:0] prevSrc
);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (busOut == '0) && !busOe);
  a_r8_drive: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> busOe);
  a_r7_rd_follows_wr: assert property (@(posedge clk) disable iff (!rstN)
    strb.fifoWr |-> ##2 strb.fifoRd);
  a_r6_clear_prev: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearPrev |=> prevSrc == '0);
  a_r2_src_moves_pair: assert property (@(posedge clk) disable iff (!rstN)
    strb.toSrc && !strb.clearPrev |=> prevSrc == $past(curSrc));
  a_r2_dst_keeps_src: assert property (@(posedge clk) disable iff (!rstN)
    strb.toDst && !strb.clearPrev |=> $stable(curSrc) && $stable(prevSrc));
endmodule

bind blit_word_unit blit_word_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .outEn(outEn), .busOut(busOut), .busOe(busOe),
  .strb(strb), .curSrc(curSrc), .prevSrc(prevSrc)
);

// File: tb/blit_word_unit_bench.sv
`timescale 1ns/1ps
module blit_word_unit_bench;
  logic clk = 1'b0;
  logic rstN;
  logic [15:0] busIn, leftMask, rightMask, busOut;
  logic latchStb, srcCycle, lineStart, leftEn, rightEn, outEn, busOe;
  logic [3:0] shiftAmt, funcSel;

  int checks = 0;
  int errors = 0;
  logic [15:0] mCur = 16'h0, mPrev = 16'h0, mS = 16'h0, mD = 16'h0;

  always #4 clk = ~clk;

  blit_word_unit u_blit_word_unit (
    .clk(clk), .rstN(rstN), .busIn(busIn), .latchStb(latchStb),
    .srcCycle(srcCycle), .lineStart(lineStart), .shiftAmt(shiftAmt),
    .funcSel(funcSel), .leftEn(leftEn), .rightEn(rightEn),
    .leftMask(leftMask), .rightMask(rightMask), .outEn(outEn),
    .busOut(busOut), .busOe(busOe)
  );

  function automatic logic [15:0] fnModel(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
    case (c)
      4'b0000: return 16'h0000;
      4'b0001: return ~s & ~d;
      4'b0010: return ~s & d;
      4'b0011: return ~s;
      4'b0100: return s & ~d;
      4'b0101: return ~d;
      4'b0110: return s ^ d;
      4'b0111: return ~s | ~d;
      4'b1000: return s & d;
      4'b1001: return ~(s ^ d);
      4'b1010: return d;
      4'b1011: return ~s | d;
      4'b1100: return s;
      4'b1101: return s | ~d;
      4'b1110: return s | d;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] alignModel(input logic [15:0] p, input logic [15:0] c, input logic [3:0] sh);
    logic [31:0] r;
    r = ({p, c} << sh) | ({p, c} >> (32 - int'(sh)));
    return r[31:16];
  endfunction

  function automatic logic [15:0] expResult();
    logic [15:0] m;
    m = (leftEn ? leftMask : 16'hFFFF) & (rightEn ? rightMask : 16'hFFFF);
    return (fnModel(funcSel, mS, mD) & m) | (mD & ~m);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic probe(input string tag);
    outEn = 1'b1;
    #1;
    check(tag, busOut, expResult());
    outEn = 1'b0;
  endtask

  task automatic pulseLatch(input logic [15:0] w, input logic isSrc);
    @(negedge clk);
    busIn = w; srcCycle = isSrc; latchStb = 1'b1;
    @(negedge clk);
    latchStb = 1'b0;
  endtask

  task automatic srcRead(input logic [15:0] w);
    pulseLatch(w, 1'b1);
    repeat (5) @(negedge clk);
    mPrev = mCur; mCur = w; mS = alignModel(mPrev, mCur, shiftAmt);
  endtask

  task automatic dstRead(input logic [15:0] w);
    pulseLatch(w, 1'b0);
    repeat (2) @(negedge clk);
    mD = w;
  endtask

  task automatic newLine();
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    mPrev = 16'h0; mCur = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rstN = 1'b0; busIn = '0; latchStb = 0; srcCycle = 0; lineStart = 0;
    shiftAmt = '0; funcSel = '0; leftEn = 0; rightEn = 0;
    leftMask = '0; rightMask = '0; outEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R8: reset state and idle bus
    check("R1 busOut idle", busOut, 16'h0);
    check("R8 busOe idle", {15'h0, busOe}, 16'h0);
    funcSel = 4'b1111; probe("R1 ones after reset");
    funcSel = 4'b1010; probe("R1 dest zero after reset");
    outEn = 1'b1; #1;
    check("R8 busOe driven", {15'h0, busOe}, 16'h1);
    outEn = 1'b0;

    // R4: all codes on a pair covering every (s,d) combination
    shiftAmt = 4'd0;
    srcRead(16'h0F0F);
    srcRead(16'h1234);   // with shift 0 the aligned word is the previous one
    dstRead(16'h3355);
    for (int c = 0; c < 16; c++) begin
      funcSel = 4'(c);
      probe($sformatf("R4 code %0d", c));
    end

    // R2: destination read leaves source path, source read leaves destination
    funcSel = 4'b1100;
    dstRead(16'hA5A5);
    probe("R2 source kept after dest read");
    funcSel = 4'b1010;
    shiftAmt = 4'd4;
    srcRead(16'hBEEF);
    probe("R2 dest kept after source read");
    funcSel = 4'b1100;
    probe("R3 shift 4 mid-line");

    // R6: line start clears previous word
    newLine();
    shiftAmt = 4'd0;
    srcRead(16'hC3C3);
    probe("R6 shift 0 after line start");
    newLine();
    shiftAmt = 4'd15;
    srcRead(16'h8001);
    probe("R6 R3 shift 15 after line start");

    // R7: arrival cycle of a new source word
    shiftAmt = 4'd0;
    funcSel = 4'b1100;
    leftEn = 0; rightEn = 0;
    pulseLatch(16'h7E7E, 1'b1);  // now just after E0
    repeat (3) @(negedge clk);   // after E3
    probe("R7 old source until E4");
    @(negedge clk);              // after E4
    mPrev = mCur; mCur = 16'h7E7E; mS = alignModel(mPrev, mCur, shiftAmt);
    probe("R7 new source after E4");
    repeat (2) @(negedge clk);

    // R5: masks
    funcSel = 4'b1111;
    dstRead(16'h0000);
    leftEn = 1; leftMask = 16'hFFF0;
    probe("R5 left mask keeps low bits");
    leftEn = 0; rightEn = 1; rightMask = 16'h03FF;
    probe("R5 right mask keeps high bits");
    leftEn = 1; leftMask = 16'hFF00;
    probe("R5 both masks");
    leftEn = 0; rightEn = 0;

    // random mix
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(3) == 0) newLine();
      shiftAmt = 4'($urandom_range(15));
      srcRead(16'($urandom));
      if ($urandom_range(1) == 1) srcRead(16'($urandom));
      dstRead(16'($urandom));
      funcSel = 4'($urandom_range(15));
      leftEn = 1'($urandom_range(1)); rightEn = 1'($urandom_range(1));
      leftMask = 16'($urandom); rightMask = 16'($urandom);
      probe($sformatf("R3 R4 R5 random %0d", i));
      @(negedge clk);
      check("R8 quiet after probe", busOut, 16'h0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule